// File: doc/BRIEF.md
# Descriptor-ring transmit DMA reader

This block moves outgoing packets from system memory to a MAC-facing word stream. Software keeps a circular ring of descriptors in memory and programs where the ring starts and how many entries it has. Each descriptor is two 32-bit words. The first word is the buffer address and the second is the buffer length in bytes. To hand buffers over, software writes a count of newly filled descriptors. The engine then walks the ring by itself. For each entry it reads the two descriptor words over a 32-bit Wishbone master, reads the referenced data word by word, and places the words in an output FIFO. The MAC drains that FIFO as a valid/ready stream.

An owned-count output tells software how many handed-over buffers the engine has not yet finished reading. The count goes up by the pushed amount and down by one when a buffer is done. Software can therefore tell how many buffers have gone out and how many ring slots it may refill. The fetch controller has five states:
- `ST_IDLE` waits for a nonzero owned count.
- `ST_DESC_ADR` reads the address word.
- `ST_DESC_LEN` reads the length word.
- `ST_DATA` reads buffer words.
- `ST_DONE` advances the ring index.

The transitions are:
- IDLE to DESC_ADR when the engine owns buffers.
- DESC_ADR to DESC_LEN when the address word is acknowledged.
- DESC_LEN to DATA when the length is nonzero, or DESC_LEN to DONE when the length is zero.
- DATA to DONE when the final word is acknowledged.
- DONE to IDLE unconditionally.

Top module: `txring_dma`

## Requirements
- R1: While reset is held and on the first cycle after it, `owned_count` is 0, `wb_cyc_o`/`wb_stb_o` are low and `st_valid` is low.
- R2: A cycle with `push_valid` high adds `push_count` to `owned_count` on the next edge. A push with `push_count` = 0 leaves the count unchanged.
- R3: The acknowledge that finishes a buffer lowers `owned_count` by one on the same edge. When a push lands on that same edge, the count takes the net value, old + pushed − 1.
- R4: For ring index i, the engine reads the address word at `ring_base + 8*i`, then the length word at `ring_base + 8*i + 4`, then data words from the buffer address upward in steps of 4. The low two address bits of the buffer address are ignored. Only the low 16 bits of the length word count.
- R5: After the entry with index `ring_size − 1`, the index wraps to 0. A `ring_size` of 0 behaves as 1.
- R6: Each data word becomes one stream beat, with byte 0 on bits 7:0. `st_last` is high only on the last word of a buffer. `st_keep` is 4'b1111 except on a last word when the length mod 4 is 1, 2 or 3; then it is 4'b0001, 4'b0011 or 4'b0111.
- R7: A descriptor with length 0 produces no beat and completes when its length word is acknowledged.
- R8: A read that ends with `wb_err_i` pushes no data and completes nothing. The engine drops the strobe for at least one cycle and re-issues the same address.
- R9: No data read is issued while the FIFO holds more than `FIFO_DEPTH − FIFO_MARGIN` words, so the FIFO never holds more than `FIFO_DEPTH − FIFO_MARGIN + 1`.
- R10: While `owned_count` is 0, no bus cycle is active.
- R11: Only one read is outstanding at a time. `wb_cyc_o` equals `wb_stb_o`, and strobe and address stay stable until `wb_ack_i` or `wb_err_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of descriptor entry 0 |
| ring_size | input | IDX_W | Number of ring entries |
| push_valid | input | 1 | Software hands over buffers this cycle |
| push_count | input | CNT_W | Number of buffers handed over |
| owned_count | output | CNT_W | Buffers held by the engine and not yet fully read |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable, always 0 |
| wb_sel_o | output | 4 | Wishbone byte selects, always all ones |
| wb_adr_o | output | 32 | Wishbone byte address |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error |
| st_valid | output | 1 | Stream beat available |
| st_ready | input | 1 | Stream sink accepts the beat |
| st_data | output | 32 | Stream data, little-endian lanes |
| st_keep | output | 4 | Valid byte lanes |
| st_last | output | 1 | Final beat of a buffer |

## Verification
A software push and the completion of a buffer can fall on the same clock edge, and both change `owned_count`. The bench's memory model knows which acknowledge finishes a buffer: the last data word, or the length word of a zero-length entry. On many of those cycles it deliberately drives a push in the same cycle. The bench keeps its own running count of pushes minus completions and compares it with `owned_count` after every edge. It also confirms at the end that such coincidences actually occurred.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_ADR,
        ST_DESC_LEN,
        ST_DATA,
        ST_DONE
    } fetch_state_t;

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  keep;
        logic        last;
    } beat_t;

    localparam int BEAT_W = $bits(beat_t);

    function automatic logic [3:0] tail_keep(input logic [1:0] rem);
        logic [3:0] k;
        unique case (rem)
            2'd1:    k = 4'b0001;
            2'd2:    k = 4'b0011;
            2'd3:    k = 4'b0111;
            default: k = 4'b1111;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/txr_fifo.sv
module txr_fifo
    import txr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  beat_t                     wr_beat,
    input  logic                      rd_en,
    output beat_t                     rd_beat,
    output logic                      empty,
    output logic                      full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    beat_t              store [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [LVL_W-1:0]   fill;
    logic               do_wr;
    logic               do_rd;

    assign empty   = (fill == '0);
    assign full    = (fill == LVL_W'(DEPTH));
    assign level   = fill;
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_beat = store[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) begin
            store[wr_ptr] <= wr_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/txr_owned.sv
module txr_owned #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [CNT_W-1:0] push_count,
    input  logic             buf_done,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] add_amt;
    logic [CNT_W-1:0] count_q;

    assign add_amt = push_valid ? push_count : '0;
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + add_amt - CNT_W'(buf_done);
        end
    end

endmodule

// File: rtl/txr_fetch.sv
module txr_fetch
    import txr_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ring_base,
    input  logic [IDX_W-1:0]  ring_size,
    input  logic              owned_nz,
    input  logic              fifo_room,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic [31:0]       wb_adr,
    input  logic [31:0]       wb_dat,
    input  logic              wb_ack,
    input  logic              wb_err,
    output logic              beat_wr,
    output beat_t             beat,
    output logic              buf_done
);
    fetch_state_t      state_q, state_d;
    logic              rd_active;
    logic [31:0]       adr_q;
    logic [31:0]       buf_adr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [IDX_W-1:0]  idx_q;
    logic              bus_ok;
    logic              bus_bad;
    logic              want_rd;
    logic              last_word;
    logic [IDX_W:0]    idx_next;

    assign bus_ok    = rd_active && wb_ack;
    assign bus_bad   = rd_active && wb_err && !wb_ack;
    assign last_word = (rem_q <= LEN_W'(4));
    assign idx_next  = {1'b0, idx_q} + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (owned_nz) state_d = ST_DESC_ADR;
            ST_DESC_ADR: if (bus_ok) state_d = ST_DESC_LEN;
            ST_DESC_LEN: if (bus_ok) state_d = (wb_dat[LEN_W-1:0] == '0) ? ST_DONE : ST_DATA;
            ST_DATA:     if (bus_ok && last_word) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        want_rd    = 1'b0;
        beat_wr    = 1'b0;
        buf_done   = 1'b0;
        beat.data  = wb_dat;
        beat.last  = last_word;
        beat.keep  = last_word ? tail_keep(rem_q[1:0]) : 4'b1111;
        unique case (state_q)
            ST_DESC_ADR: want_rd = 1'b1;
            ST_DESC_LEN: begin
                want_rd  = 1'b1;
                buf_done = bus_ok && (wb_dat[LEN_W-1:0] == '0);
            end
            ST_DATA: begin
                want_rd  = fifo_room;
                beat_wr  = bus_ok;
                buf_done = bus_ok && last_word;
            end
            default: ;
        endcase
    end

    assign wb_cyc = rd_active;
    assign wb_stb = rd_active;
    assign wb_adr = adr_q;

    // bus request and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            adr_q     <= '0;
            buf_adr_q <= '0;
            rem_q     <= '0;
            idx_q     <= '0;
        end else begin
            if (bus_ok || bus_bad) begin
                rd_active <= 1'b0;
            end else if (!rd_active && want_rd) begin
                rd_active <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (owned_nz) begin
                        adr_q <= ring_base + {{(29-IDX_W){1'b0}}, idx_q, 3'b000};
                    end
                end
                ST_DESC_ADR: begin
                    if (bus_ok) begin
                        buf_adr_q <= {wb_dat[31:2], 2'b00};
                        adr_q     <= adr_q + 32'd4;
                    end
                end
                ST_DESC_LEN: begin
                    if (bus_ok) begin
                        rem_q <= wb_dat[LEN_W-1:0];
                        adr_q <= buf_adr_q;
                    end
                end
                ST_DATA: begin
                    if (bus_ok) begin
                        adr_q <= adr_q + 32'd4;
                        rem_q <= last_word ? '0 : rem_q - LEN_W'(4);
                    end
                end
                ST_DONE: begin
                    idx_q <= (idx_next >= {1'b0, ring_size}) ? '0 : idx_next[IDX_W-1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txr_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int LEN_W       = 16,
    parameter int FIFO_DEPTH  = 16,
    parameter int FIFO_MARGIN = 2,
    parameter int CNT_W       = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ring_base,
    input  logic [IDX_W-1:0]  ring_size,
    input  logic              push_valid,
    input  logic [CNT_W-1:0]  push_count,
    output logic [CNT_W-1:0]  owned_count,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [3:0]        wb_sel_o,
    output logic [31:0]       wb_adr_o,
    input  logic [31:0]       wb_dat_i,
    input  logic              wb_ack_i,
    input  logic              wb_err_i,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [31:0]       st_data,
    output logic [3:0]        st_keep,
    output logic              st_last
);
    localparam int LVL_W      = $clog2(FIFO_DEPTH+1);
    localparam int ROOM_LIMIT = FIFO_DEPTH - FIFO_MARGIN;

    logic              buf_done;
    logic              beat_wr;
    beat_t             wr_beat;
    beat_t             rd_beat;
    logic              fifo_empty;
    logic              fifo_full;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_room;

    assign fifo_room = (fifo_level <= LVL_W'(ROOM_LIMIT));
    assign wb_we_o   = 1'b0;
    assign wb_sel_o  = 4'b1111;

    txr_owned #(.CNT_W(CNT_W)) u_owned (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_count (push_count),
        .buf_done   (buf_done),
        .count      (owned_count)
    );

    txr_fetch #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .ring_size (ring_size),
        .owned_nz  (|owned_count),
        .fifo_room (fifo_room),
        .wb_cyc    (wb_cyc_o),
        .wb_stb    (wb_stb_o),
        .wb_adr    (wb_adr_o),
        .wb_dat    (wb_dat_i),
        .wb_ack    (wb_ack_i),
        .wb_err    (wb_err_i),
        .beat_wr   (beat_wr),
        .beat      (wr_beat),
        .buf_done  (buf_done)
    );

    txr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (beat_wr),
        .wr_beat (wr_beat),
        .rd_en   (st_ready),
        .rd_beat (rd_beat),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .level   (fifo_level)
    );

    assign st_valid = !fifo_empty;
    assign st_data  = rd_beat.data;
    assign st_keep  = rd_beat.keep;
    assign st_last  = rd_beat.last;

endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] owned_count,
    input logic             wb_stb_o,
    input logic             wb_cyc_o,
    input logic [31:0]      wb_adr_o,
    input logic             wb_ack_i,
    input logic             wb_err_i,
    input logic             st_valid,
    input logic [3:0]       st_keep,
    input logic             st_last,
    input logic             fifo_wr,
    input logic             fifo_full
);
    // R11
    stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !wb_ack_i && !wb_err_i) |=> (wb_stb_o && $stable(wb_adr_o)));

    // R8
    err_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && wb_err_i && !wb_ack_i) |=> (!wb_stb_o && $stable(wb_adr_o)));

    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owned_count == '0) |-> !wb_cyc_o);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);

    // R6
    keep_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_last) |-> (st_keep == 4'b1111));

    // R6
    keep_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_last) |-> (st_keep != 4'b0000));

endmodule

bind txring_dma txring_dma_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .owned_count (owned_count),
    .wb_stb_o    (wb_stb_o),
    .wb_cyc_o    (wb_cyc_o),
    .wb_adr_o    (wb_adr_o),
    .wb_ack_i    (wb_ack_i),
    .wb_err_i    (wb_err_i),
    .st_valid    (st_valid),
    .st_keep     (st_keep),
    .st_last     (st_last),
    .fifo_wr     (beat_wr),
    .fifo_full   (fifo_full)
);

// File: tb/txring_dma_bench.sv
`timescale 1ns/1ps
module txring_dma_bench;
    localparam int IDX_W     = 8;
    localparam int CNT_W     = IDX_W + 1;
    localparam int DEPTH     = 16;
    localparam int MARGIN    = 2;
    localparam int RS        = 5;
    localparam logic [31:0] RING_BASE = 32'h0000_1000;
    localparam logic [31:0] DATA_BASE = 32'h0001_0000;
    localparam int WD_LIMIT  = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      ring_base = RING_BASE;
    logic [IDX_W-1:0] ring_size = IDX_W'(RS);
    logic             push_valid = 1'b0;
    logic [CNT_W-1:0] push_count = '0;
    logic [CNT_W-1:0] owned_count;
    logic             wb_cyc_o, wb_stb_o, wb_we_o;
    logic [3:0]       wb_sel_o;
    logic [31:0]      wb_adr_o;
    logic [31:0]      wb_dat_i = '0;
    logic             wb_ack_i = 1'b0;
    logic             wb_err_i = 1'b0;
    logic             st_valid, st_last;
    logic             st_ready = 1'b0;
    logic [31:0]      st_data;
    logic [3:0]       st_keep;

    always #2 clk = ~clk;

    txring_dma u_txring_dma (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_size(ring_size),
        .push_valid(push_valid), .push_count(push_count), .owned_count(owned_count),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o),
        .wb_adr_o(wb_adr_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
        .st_keep(st_keep), .st_last(st_last)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lens [RS];
    logic [36:0] exp_q [$];
    int exp_owned = 0, prev_push = 0, prev_done = 0;
    int push_slot = 0, eng_slot = 0;
    int inflight = 0;
    int conc_hits = 0, zero_done = 0, done_total = 0, err_total = 0;
    bit req_seen = 0, retry_pend = 0;
    logic [31:0] retry_adr = '0;
    int wait_left = 0;
    int ready_mode = 0;     // 0 random, 1 always, 2 never
    bit push_en = 0, err_en = 0, zero_push = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    function automatic int nwords(input int len);
        return (len + 3) / 4;
    endfunction

    function automatic logic [31:0] buf_addr(input int s);
        return DATA_BASE + 32'(s) * 32'h1000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic enqueue_slot(input int s);
        int nw = nwords(lens[s]);
        for (int w = 0; w < nw; w++) begin
            logic [3:0] k;
            logic lst = (w == nw - 1);
            k = 4'b1111;
            if (lst && (lens[s] % 4) != 0) k = 4'((1 << (lens[s] % 4)) - 1);
            exp_q.push_back({mem_word(buf_addr(s) + 32'(4*w)), k, lst});
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic tick();
        bit ack_r, err_r, done_now;
        logic [31:0] dat_r;
        int n;
        @(negedge clk);
        cycles++;
        if (cycles > WD_LIMIT) begin
            chk(1'b0, "WD", "watchdog expired", 64'(cycles), 64'(WD_LIMIT));
            finish_run();
        end
        exp_owned = exp_owned + prev_push - prev_done;
        prev_push = 0;
        prev_done = 0;
        // R2 R3: running count of pushes minus completions
        chk(int'(owned_count) == exp_owned, "R2/R3", "owned_count", 64'(owned_count), 64'(exp_owned));
        // R9: words held in the FIFO after the coming edge
        chk(inflight <= DEPTH - MARGIN + 1, "R9", "fifo occupancy", 64'(inflight), 64'(DEPTH - MARGIN + 1));

        ack_r = 0; err_r = 0; done_now = 0; dat_r = '0;
        if (wb_cyc_o && wb_stb_o) begin
            if (!req_seen) begin
                req_seen = 1;
                wait_left = $urandom % 3;
                if (retry_pend) begin
                    chk(wb_adr_o == retry_adr, "R8", "retry address", 64'(wb_adr_o), 64'(retry_adr));
                    retry_pend = 0;
                end else if (wb_adr_o >= RING_BASE && wb_adr_o < RING_BASE + 32'(8*RS) && !wb_adr_o[2]) begin
                    // R4 R5: descriptor fetch order around the ring
                    chk(wb_adr_o == RING_BASE + 32'(8*eng_slot), "R5", "descriptor address",
                        64'(wb_adr_o), 64'(RING_BASE + 32'(8*eng_slot)));
                end
            end
            if (wait_left == 0) begin
                req_seen = 0;
                if (err_en && ($urandom % 8) == 0) begin
                    err_r = 1; retry_pend = 1; retry_adr = wb_adr_o; err_total++;
                end else begin
                    ack_r = 1;
                    if (wb_adr_o >= RING_BASE && wb_adr_o < RING_BASE + 32'(8*RS)) begin
                        int s = int'((wb_adr_o - RING_BASE) >> 3);
                        if (wb_adr_o[2]) begin
                            dat_r = 32'(lens[s]);
                            if (lens[s] == 0) begin done_now = 1; zero_done++; end
                        end else begin
                            dat_r = buf_addr(s) | 32'h2;  // low bits must be ignored (R4)
                        end
                    end else begin
                        int s = int'((wb_adr_o - DATA_BASE) >> 12);
                        dat_r = mem_word(wb_adr_o);
                        inflight++;
                        if (int'(wb_adr_o[11:0]) == 4*(nwords(lens[s]) - 1)) done_now = 1;
                    end
                    if (done_now) begin
                        eng_slot = (eng_slot + 1) % RS;
                        done_total++;
                    end
                end
            end else begin
                wait_left--;
            end
        end
        wb_ack_i = ack_r;
        wb_err_i = err_r;
        wb_dat_i = dat_r;
        prev_done = done_now ? 1 : 0;

        push_valid = 0;
        push_count = '0;
        if (zero_push) begin
            push_valid = 1;
        end else if (push_en) begin
            int room = RS - (exp_owned - prev_done);
            n = 0;
            if (done_now && room > 0 && ($urandom % 2) == 0) begin
                n = 1; conc_hits++;
            end else if (($urandom % 6) == 0 && room > 0) begin
                n = 1 + ($urandom % room);
            end else if (($urandom % 16) == 0) begin
                push_valid = 1;  // count 0, must not change owned_count (R2)
            end
            if (n > 0) begin
                push_valid = 1;
                push_count = CNT_W'(n);
                prev_push = n;
                for (int i = 0; i < n; i++) begin
                    enqueue_slot(push_slot);
                    push_slot = (push_slot + 1) % RS;
                end
            end
        end

        case (ready_mode)
            1: st_ready = 1;
            2: st_ready = 0;
            default: st_ready = (($urandom % 10) < 7);
        endcase
        #1;
        if (st_valid && st_ready) begin
            inflight--;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected beat", 64'({st_data, st_keep, st_last}), 64'(0));
            end else begin
                logic [36:0] e = exp_q.pop_front();
                // R6 R7: data, keep and last against the descriptor contents
                chk({st_data, st_keep, st_last} == e, "R6", "stream beat",
                    64'({st_data, st_keep, st_last}), 64'(e));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < RS; i++) lens[i] = $urandom_range(1, 60);
        lens[1] = 0;
        lens[2] = 97;
        lens[3] = 4;

        repeat (4) @(negedge clk);
        // R1: state under reset
        chk(owned_count == '0, "R1", "owned in reset", 64'(owned_count), 64'(0));
        chk(!wb_cyc_o && !st_valid, "R1", "bus/stream idle in reset", 64'({wb_cyc_o, st_valid}), 64'(0));
        rst_n = 1;
        tick();
        chk(!wb_cyc_o && !st_valid, "R1", "idle after reset", 64'({wb_cyc_o, st_valid}), 64'(0));

        // R2 R10: zero-count push changes nothing, bus stays quiet
        zero_push = 1;
        tick();
        zero_push = 0;
        repeat (4) tick();
        chk(owned_count == '0 && !wb_cyc_o, "R10", "no bus cycle with nothing owned",
            64'({owned_count, wb_cyc_o}), 64'(0));

        // random traffic with bus errors and concurrent push/complete
        push_en = 1; err_en = 1; ready_mode = 0;
        repeat (3000) tick();

        // sink stalled: FIFO must stop near full (R9)
        ready_mode = 2;
        repeat (120) tick();
        ready_mode = 0;
        repeat (1500) tick();

        // drain
        push_en = 0; ready_mode = 1;
        for (int g = 0; g < 20000 && (exp_q.size() != 0 || exp_owned != 0); g++) tick();
        repeat (10) tick();
        chk(exp_q.size() == 0, "R6", "all expected beats delivered", 64'(exp_q.size()), 64'(0));
        chk(owned_count == '0 && !wb_cyc_o, "R10", "idle after drain", 64'({owned_count, wb_cyc_o}), 64'(0));
        chk(conc_hits > 0, "R3", "push coincided with completion", 64'(conc_hits), 64'(1));
        chk(zero_done > 0, "R7", "zero-length completions seen", 64'(zero_done), 64'(1));
        chk(done_total > 2 * RS, "R5", "ring wrapped several times", 64'(done_total), 64'(2 * RS + 1));
        chk(err_total > 0, "R8", "bus errors injected", 64'(err_total), 64'(1));
        finish_run();
    end
endmodule